// File: doc/BRIEF.md
# EEPROM Byte-Write Sequencer with Completion Detection

This block sits on the host side of a byte-wide, self-timed EEPROM. A client presents a request with an address and a data byte. The sequencer drives the memory's address, data, chip-select, write-strobe and output-enable pins so that every set-up, pulse-width and hold minimum is met. Each minimum is given in nanoseconds and converted to whole clock cycles, rounded up, at elaboration. After the strobe it waits out the memory's busy-assert delay. It then detects the end of the internal write cycle in one of two ways, chosen per request.

In status mode the sequencer watches an active-high ready input. In polling mode it reads back the address just written until the top data bit matches the written value. While the internal write is still running, the memory returns the complement of that bit. The outcome is reported as a one-cycle done pulse. The pulse carries a timeout flag if completion is not seen within a cycle bound derived from the worst-case write time. No new request is taken while a write is pending.

Top module: `eeprom_write_seq`

## Requirements
- R1: `req_ready_o` is high only when the sequencer is idle. A request is taken on a clock edge where both `req_i` and `req_ready_o` are high. That edge latches the address, the data and `poll_mode_i`. Requests presented while a write is pending are ignored and change neither the address nor the data written.
- R2: From the accepting edge, address and data are driven and CE is low (`mem_ce_n_o`=0) with WE high for S = ceil(T_ADDR_SETUP_NS/CLK_NS) cycles (minimum 1) before WE falls.
- R3: WE stays low (`mem_we_n_o`=0) for W cycles, the largest of ceil(strobe width), ceil(address hold) and ceil(data set-up) over CLK_NS. During that time OE stays high and the data is driven.
- R4: After WE rises, address, data and CE low are held, with OE high, for H = max(ceil(T_DATA_HOLD_NS/CLK_NS), ceil(T_OE_GUARD_NS/CLK_NS)) cycles. The address does not change while a write is pending.
- R5: After the hold phase, the bus stays released, and neither ready nor read data is sampled, for B = ceil(T_BUSY_DLY_NS/CLK_NS) cycles.
- R6: In status mode (`poll_mode_i`=0 at acceptance), the first edge of the wait phase at which `mem_ready_i`=1 is followed by a single-cycle `done_o` with `timeout_o`=0. The sequencer is idle again the next cycle.
- R7: In polling mode (`poll_mode_i`=1), each poll drives the written address with CE and OE low for R = ceil(T_ACCESS_NS/CLK_NS) cycles. Bit DW-1 of `mem_rdata_i` is sampled on the last edge. If it equals the written bit, the done pulse follows. Otherwise CE and OE go high for one cycle and the poll repeats.
- R8: With T = ceil(T_WRITE_MAX_NS/CLK_NS), a write whose completion is not seen by the edge S+W+H+T cycles after acceptance ends with `done_o`=1 and `timeout_o`=1 in that cycle. If completion is seen on that same edge, completion wins.
- R9: After reset, CE, WE and OE are high, the data bus is not driven, `done_o` and `timeout_o` are low and `req_ready_o` is high.
- R10: While OE is low, WE is high and the sequencer does not drive the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request |
| req_addr_i | input | AW | Byte address to write |
| req_data_i | input | DW | Byte to write |
| poll_mode_i | input | 1 | 1: detect completion by data polling, 0: by ready input |
| req_ready_o | output | 1 | Idle, request can be taken |
| done_o | output | 1 | One-cycle end-of-write pulse |
| timeout_o | output | 1 | Qualifies done_o: write did not complete in the bound |
| mem_addr_o | output | AW | Memory address pins |
| mem_wdata_o | output | DW | Data to drive onto the memory data bus |
| mem_wdata_oe_o | output | 1 | Drive enable for mem_wdata_o |
| mem_rdata_i | input | DW | Data read from the memory bus |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_ready_i | input | 1 | Memory ready (high) / busy (low) status |

## Verification
Counted from the accepting edge as cycle 0, WE falls in cycle S, rises in cycle S+W, and CE is released in cycle S+W+H. The first poll read starts in cycle S+W+H+B. The done pulse comes in the first cycle at which a sampled completion is possible, or in cycle S+W+H+T on timeout. The bench models the memory with a busy time that it sweeps across short, mid-range and both sides of the timeout boundary, in both modes. It samples every pin on the falling clock edge with a cycle index and compares each event cycle against these formulas, evaluated arithmetically from the nanosecond parameters.

// File: rtl/ews_pkg.sv
package ews_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_WAIT_BUSY,
    ST_WAIT_RDY,
    ST_POLL,
    ST_POLL_GAP,
    ST_DONE,
    ST_ERROR
  } ews_state_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ews_phase_timer.sv
module ews_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/ews_window_ctr.sv
module ews_window_ctr #(
  parameter int unsigned W     = 20,
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  localparam logic [W-1:0] LastVal = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (!expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LastVal);

endmodule

// File: rtl/ews_bus_ctrl.sv
module ews_bus_ctrl import ews_pkg::*; #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ews_state_e    state_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_wdata_oe_o,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  // pins decoded straight from the state register
  always_comb begin
    mem_ce_n_o     = 1'b1;
    mem_we_n_o     = 1'b1;
    mem_oe_n_o     = 1'b1;
    mem_wdata_oe_o = 1'b0;
    unique case (state_i)
      ST_SETUP, ST_HOLD: begin
        mem_ce_n_o     = 1'b0;
        mem_wdata_oe_o = 1'b1;
      end
      ST_STROBE: begin
        mem_ce_n_o     = 1'b0;
        mem_we_n_o     = 1'b0;
        mem_wdata_oe_o = 1'b1;
      end
      ST_POLL: begin
        mem_ce_n_o = 1'b0;
        mem_oe_n_o = 1'b0;
      end
      default: ;
    endcase
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;

  assert_strobe_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && !mem_ce_n_o && mem_wdata_oe_o))
    else $error("strobe without OE high, CE low and data driven");

  assert_no_contention_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_wdata_oe_o))
    else $error("read overlaps write drive");

  assert_addr_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |-> $stable(mem_addr_o))
    else $error("address moved during pending write");

  assert_hold_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_wdata_oe_o && !mem_ce_n_o && $stable(mem_wdata_o)))
    else $error("data or CE dropped at strobe rise");

endmodule

// File: rtl/eeprom_write_seq.sv
module eeprom_write_seq import ews_pkg::*; #(
  parameter int unsigned AW              = 13,
  parameter int unsigned DW              = 8,
  parameter int unsigned CLK_NS          = 4,
  parameter int unsigned T_ADDR_SETUP_NS = 10,
  parameter int unsigned T_ADDR_HOLD_NS  = 100,
  parameter int unsigned T_STROBE_NS     = 150,
  parameter int unsigned T_DATA_SETUP_NS = 120,
  parameter int unsigned T_DATA_HOLD_NS  = 10,
  parameter int unsigned T_OE_GUARD_NS   = 10,
  parameter int unsigned T_BUSY_DLY_NS   = 50,
  parameter int unsigned T_ACCESS_NS     = 300,
  parameter int unsigned T_WRITE_MAX_NS  = 3000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          poll_mode_i,
  output logic          req_ready_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_wdata_oe_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  input  logic          mem_ready_i
);

  localparam int unsigned SetupCyc  = ns_to_cyc(T_ADDR_SETUP_NS, CLK_NS);
  localparam int unsigned StrobeCyc = max2(ns_to_cyc(T_STROBE_NS, CLK_NS),
                                      max2(ns_to_cyc(T_ADDR_HOLD_NS, CLK_NS),
                                           ns_to_cyc(T_DATA_SETUP_NS, CLK_NS)));
  localparam int unsigned HoldCyc   = max2(ns_to_cyc(T_DATA_HOLD_NS, CLK_NS),
                                           ns_to_cyc(T_OE_GUARD_NS, CLK_NS));
  localparam int unsigned BusyCyc   = ns_to_cyc(T_BUSY_DLY_NS, CLK_NS);
  localparam int unsigned ReadCyc   = ns_to_cyc(T_ACCESS_NS, CLK_NS);
  localparam int unsigned LimitCyc  = ns_to_cyc(T_WRITE_MAX_NS, CLK_NS);
  localparam int unsigned PhaseMax  = max2(max2(SetupCyc, StrobeCyc),
                                      max2(max2(HoldCyc, BusyCyc), ReadCyc));
  localparam int unsigned PhaseW    = $clog2(PhaseMax + 1);
  localparam int unsigned LimW      = $clog2(LimitCyc + 1);

  localparam logic [PhaseW-1:0] LdSetup  = PhaseW'(SetupCyc - 1);
  localparam logic [PhaseW-1:0] LdStrobe = PhaseW'(StrobeCyc - 1);
  localparam logic [PhaseW-1:0] LdHold   = PhaseW'(HoldCyc - 1);
  localparam logic [PhaseW-1:0] LdBusy   = PhaseW'(BusyCyc - 1);
  localparam logic [PhaseW-1:0] LdRead   = PhaseW'(ReadCyc - 1);

  ews_state_e        state_q, state_d;
  logic              poll_mode_q;
  logic              accept;
  logic              tmr_load;
  logic [PhaseW-1:0] tmr_val;
  logic              tmr_last;
  logic              win_run;
  logic              win_exp;
  logic              poll_hit;
  logic              unused_rdata;

  assign accept       = (state_q == ST_IDLE) && req_i;
  assign poll_hit     = (mem_rdata_i[DW-1] == mem_wdata_o[DW-1]);
  assign unused_rdata = ^mem_rdata_i[DW-2:0];
  assign win_run      = (state_q == ST_WAIT_BUSY) || (state_q == ST_WAIT_RDY) ||
                        (state_q == ST_POLL)      || (state_q == ST_POLL_GAP);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = LdSetup;
      end
      ST_SETUP: if (tmr_last) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = LdStrobe;
      end
      ST_STROBE: if (tmr_last) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = LdHold;
      end
      ST_HOLD: if (tmr_last) begin
        state_d  = ST_WAIT_BUSY;
        tmr_load = 1'b1;
        tmr_val  = LdBusy;
      end
      ST_WAIT_BUSY: begin
        if (win_exp) state_d = ST_ERROR;
        else if (tmr_last) begin
          if (poll_mode_q) begin
            state_d  = ST_POLL;
            tmr_load = 1'b1;
            tmr_val  = LdRead;
          end else begin
            state_d = ST_WAIT_RDY;
          end
        end
      end
      ST_WAIT_RDY: begin
        if (mem_ready_i)  state_d = ST_DONE;
        else if (win_exp) state_d = ST_ERROR;
      end
      ST_POLL: begin
        // completion seen on the last read edge beats the timeout
        if (tmr_last && poll_hit) state_d = ST_DONE;
        else if (win_exp)         state_d = ST_ERROR;
        else if (tmr_last)        state_d = ST_POLL_GAP;
      end
      ST_POLL_GAP: begin
        if (win_exp) state_d = ST_ERROR;
        else begin
          state_d  = ST_POLL;
          tmr_load = 1'b1;
          tmr_val  = LdRead;
        end
      end
      ST_DONE, ST_ERROR: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      poll_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) poll_mode_q <= poll_mode_i;
    end
  end

  ews_phase_timer #(.W(PhaseW)) phase_tmr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  ews_window_ctr #(.W(LimW), .LIMIT(LimitCyc)) window_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (win_run),
    .expired_o (win_exp)
  );

  ews_bus_ctrl #(.AW(AW), .DW(DW)) bus_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (state_q),
    .capture_i      (accept),
    .addr_i         (req_addr_i),
    .data_i         (req_data_i),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_wdata_oe_o (mem_wdata_oe_o),
    .mem_ce_n_o     (mem_ce_n_o),
    .mem_we_n_o     (mem_we_n_o),
    .mem_oe_n_o     (mem_oe_n_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE) || (state_q == ST_ERROR);
  assign timeout_o   = (state_q == ST_ERROR);

  assert_accept_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_ready_o) |=> (mem_we_n_o && !mem_ce_n_o))
    else $error("no set-up cycle before strobe");

  assert_refuse_pending_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> ($stable(mem_wdata_o) && $stable(mem_addr_o)))
    else $error("pending write disturbed by new request");

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o))
    else $error("done is not a single-cycle pulse");

  assert_timeout_qualifies_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o)
    else $error("timeout without done");

  assert_no_early_poll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |=> mem_oe_n_o)
    else $error("poll started inside busy delay");

endmodule

// File: tb/eeprom_write_seq_tb.sv
module eeprom_write_seq_tb_top;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int CLK = 4;
  localparam int TWMAX = 4000;

  function automatic int cdiv(int a, int b);
    int c;
    c = (a + b - 1) / b;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_S  = cdiv(10, CLK);
  localparam int E_W  = mx(cdiv(150, CLK), mx(cdiv(100, CLK), cdiv(120, CLK)));
  localparam int E_H  = mx(cdiv(10, CLK), cdiv(10, CLK));
  localparam int E_B  = cdiv(50, CLK);
  localparam int E_R  = cdiv(300, CLK);
  localparam int E_T  = cdiv(TWMAX, CLK);
  localparam int E_EC = E_S + E_W + E_H + E_B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_data_i = '0;
  logic          poll_mode_i = 1'b0;
  logic          req_ready_o, done_o, timeout_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_wdata_oe_o, mem_ce_n_o, mem_we_n_o, mem_oe_n_o;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ready = 1'b1;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  eeprom_write_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK), .T_WRITE_MAX_NS(TWMAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_data_i(req_data_i), .poll_mode_i(poll_mode_i), .req_ready_o(req_ready_o),
    .done_o(done_o), .timeout_o(timeout_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_wdata_oe_o(mem_wdata_oe_o), .mem_rdata_i(mem_rdata),
    .mem_ce_n_o(mem_ce_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_ready_i(mem_ready)
  );

  // memory model: commits on strobe rise, stays busy model_n cycles
  int            model_n = 1;
  int            busy_left = 0;
  int            commits = 0;
  logic          we_prev = 1'b1;
  logic [AW-1:0] cap_addr = '0;
  logic [DW-1:0] cap_data = '0;

  always @(negedge clk) begin
    if (!we_prev && mem_we_n_o && !mem_ce_n_o && mem_oe_n_o) begin
      commits++;
      cap_addr = mem_addr_o;
      cap_data = mem_wdata_o;
      busy_left = model_n;
    end else if (busy_left > 0) begin
      busy_left--;
    end
    we_prev = mem_we_n_o;
    mem_ready = (busy_left == 0);
    mem_rdata = (busy_left != 0) ? {~cap_data[DW-1], 7'h2A} : cap_data;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_done(input bit mode, input int n, output bit to);
    int base, lim, q;
    base = E_S + E_W + n;
    lim  = E_S + E_W + E_H + E_T;
    if (!mode) q = mx(E_EC + 1, base + 1);
    else begin
      q = E_EC + E_R;
      while (q - 1 < base) q += E_R + 1;
    end
    if (q <= lim) begin to = 0; return q; end
    to = 1;
    return lim;
  endfunction

  task automatic run_one(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit mode, input int n, input bit interfere);
    int c0, fall, rise, hend, oe1, got, expc;
    bit gto, eto, addr_bad;
    c0 = commits; fall = -1; rise = -1; hend = -1; oe1 = -1; got = -1;
    gto = 0; addr_bad = 0;
    model_n = n;
    req_i = 1'b1; req_addr_i = a; req_data_i = d; poll_mode_i = mode;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (interfere) begin
          req_addr_i = ~a; req_data_i = ~d; poll_mode_i = ~mode;
        end else req_i = 1'b0;
      end
      if (k == 30) req_i = 1'b0;
      if (k == 1) check(!req_ready_o, "R1 ready low while pending", int'(req_ready_o), 0);
      if (!mem_we_n_o && fall < 0) fall = k;
      if (fall >= 0 && mem_we_n_o && rise < 0) rise = k;
      if (rise >= 0 && mem_ce_n_o && hend < 0) hend = k;
      if (!mem_oe_n_o && oe1 < 0) oe1 = k;
      if (!mem_oe_n_o && mem_addr_o != a) addr_bad = 1;
      if (done_o) begin got = k; gto = timeout_o; break; end
    end
    expc = exp_done(mode, n, eto);
    check(fall == E_S, "R2 strobe fall cycle", fall, E_S);
    check(rise == E_S + E_W, "R3 strobe rise cycle", rise, E_S + E_W);
    check(hend == E_S + E_W + E_H, "R4 hold end cycle", hend, E_S + E_W + E_H);
    check(commits - c0 == 1, "R1 single write committed", commits - c0, 1);
    check(cap_addr == a, "R1 written address", int'(cap_addr), int'(a));
    check(cap_data == d, "R3 written data", int'(cap_data), int'(d));
    if (mode) begin
      check(oe1 == E_EC, "R5 first poll cycle", oe1, E_EC);
      check(!addr_bad, "R7 poll address", int'(addr_bad), 0);
    end else begin
      check(oe1 < 0, "R6 no read in status mode", oe1, -1);
    end
    check(got == expc, mode ? "R7 done cycle" : "R6 done cycle", got, expc);
    check(gto == eto, "R8 timeout flag", int'(gto), int'(eto));
    @(negedge clk);
    check(!done_o && req_ready_o, "R6 single-cycle done", int'({done_o, req_ready_o}), 1);
  endtask

  int nlist [10] = '{1, 3, 16, 60, 91, 167, 500, 1002, 1003, 5000};

  initial begin
    repeat (3) @(negedge clk);
    check({mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_wdata_oe_o, done_o, timeout_o, req_ready_o}
          == 7'b1110001, "R9 reset state",
          int'({mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_wdata_oe_o, done_o, timeout_o, req_ready_o}),
          7'b1110001);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o && mem_we_n_o && mem_oe_n_o, "R9 idle after reset", int'(req_ready_o), 1);
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 10; i++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = AW'((i * 977 + m * 4099) & ((1 << AW) - 1));
        d = DW'(i * 53 + m * 29 + ((i % 2) << 7));
        run_one(a, d, m[0], nlist[i], (i % 3) == 1);
        repeat (2) @(negedge clk);
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog R6/R7: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule